// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table kept in memory, and then decides whether the requested access is allowed. A requester presents an address, an access kind (read, write or instruction fetch) and a user/privileged flag. The walker then fetches one or two descriptors through a plain request/valid read port. It returns either the physical address together with read and write permission, or an 8-bit fault status. Every fault is also logged into a pair of status/address registers. Instruction fetches use one pair and all other accesses use the other.

Configuration arrives on four 32-bit inputs: the table base, the domain access word, a control word and a process-ID offset. Low virtual addresses are first relocated by the process-ID offset. First-level entries may be faults, 1 MB sections or pointers to coarse or fine second-level tables. Second-level entries map 64 KB, 4 KB or 1 KB pages. The 64 KB and 4 KB pages carry four 2-bit permission fields, one per quarter of the page.

Only one walk runs at a time. `busy` rises on acceptance and stays high through the single-cycle `done` or `fault` pulse that ends the walk.

Top module: `ptw_walker`

## Requirements
- R1: A request address below 0x02000000 has `cfg_pid` added before translation, and addresses from 0x02000000 upward are used unchanged. The fault address registers always log the unrelocated address.
- R2: When `cfg_ctrl` bit 0 is 0, the walk ends with `done` one cycle after acceptance. In that case `res_pa` equals the relocated address, both permissions are 1, and `mem_req` never rises.
- R3: The first descriptor is read from (`cfg_base` & 0xFFFFC000) | ((relocated VA >> 18) & 0x3FFC). If its bits [1:0] are 0, the walk faults with code 5.
- R4: The domain number is taken from first-level bits [8:5] and selects the 2-bit field at bit 2×domain of `cfg_domacc`. If that field is 0 or 2, the walk faults with code 9 when the first-level type is 2, and with code 11 otherwise.
- R5: If the selected domain field is 3, both read and write are granted and the permission field is ignored.
- R6: A first-level type of 2 is a section. The physical address is desc[31:20] joined with VA[19:0], the permission field is desc[11:10], and a refused access faults with code 13.
- R7: For first-level types 1 and 3, the second descriptor is read from (desc & 0xFFFFFC00) | ((VA >> 10) & 0x3FC). A second-level type of 0 faults with code 7. A second-level type of 3 under a first-level type of 1 also faults with code 7.
- R8: Second-level type 1 maps 64 KB pages as {desc[31:16], VA[15:0]}, using the permission field at bit 4+2×VA[15:14]. Type 2 maps 4 KB pages as {desc[31:12], VA[11:0]}, using the field at bit 4+2×VA[11:10]. Type 3 maps 1 KB pages as {desc[31:10], VA[9:0]}, using field desc[5:4]. A refused page access faults with code 15.
- R9: Permission field 3 allows everything. Field 2 gives privileged read/write and user read only. Field 1 gives privileged read/write and nothing for user. Field 0 never allows writes. Reads under field 0 depend on `cfg_ctrl[9:8]`: the value 2 allows all reads, the value 1 allows privileged reads only, and any other value allows none. A fetch is checked as a read.
- R10: `res_status` on a fault is code | (domain number << 4). `req_kind` encodes read as 0, write as 1 and fetch as 2. A fetch fault loads `ifault_status`/`ifault_addr`, and any other fault loads `dfault_status`/`dfault_addr`; the other pair keeps its value.
- R11: `busy` is high from the cycle after acceptance through the single-cycle `done` or `fault` pulse, and low after it. The two pulses never coincide. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| cfg_base | input | 32 | Translation table base |
| cfg_domacc | input | 32 | Sixteen 2-bit domain access fields |
| cfg_ctrl | input | 32 | Bit 0 translation enable, bits [9:8] field-0 read mode |
| cfg_pid | input | 32 | Process-ID relocation offset |
| mem_req | output | 1 | Descriptor read request, held until mem_valid |
| mem_addr | output | 32 | Descriptor address |
| mem_valid | input | 1 | Descriptor data valid |
| mem_data | input | 32 | Descriptor data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Fault pulse |
| res_pa | output | 32 | Physical address (valid with done) |
| res_rd | output | 1 | Read permitted |
| res_wr | output | 1 | Write permitted |
| res_status | output | 8 | Fault status (valid with fault) |
| ifault_status | output | 8 | Last fetch fault status |
| ifault_addr | output | 32 | Last fetch fault address |
| dfault_status | output | 8 | Last data fault status |
| dfault_addr | output | 32 | Last data fault address |

## Verification
The assertions assume that the configuration inputs stay constant during a walk. They also assume that `mem_valid` is raised only while `mem_req` is high. The stimulus changes configuration only between walks, while `busy` is low. The bench's memory model answers only requests it has seen, with a latency of zero to two cycles. One walk keeps `req_valid` high with a different address for its whole duration, so the rule that requests are ignored while busy is exercised at the ports.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int CODE_W = 4;
  localparam int DOM_W  = 4;
  localparam int STAT_W = CODE_W + DOM_W;

  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [CODE_W-1:0] C_L1_EMPTY  = 4'd5;
  localparam logic [CODE_W-1:0] C_L2_EMPTY  = 4'd7;
  localparam logic [CODE_W-1:0] C_DOM_SECT  = 4'd9;
  localparam logic [CODE_W-1:0] C_DOM_PAGE  = 4'd11;
  localparam logic [CODE_W-1:0] C_PERM_SECT = 4'd13;
  localparam logic [CODE_W-1:0] C_PERM_PAGE = 4'd15;

  typedef enum logic [1:0] {W_IDLE, W_LVL1, W_LVL2, W_DONE} walk_st_e;

  function automatic logic [31:0] relocate(input logic [31:0] va, input logic [31:0] pid,
                                           input logic [31:0] limit);
    return (va < limit) ? va + pid : va;
  endfunction

  function automatic logic [31:0] lvl1_addr(input logic [31:0] base, input logic [31:0] mva);
    return (base & 32'hFFFF_C000) | ((mva >> 18) & 32'h0000_3FFC);
  endfunction

  function automatic logic [31:0] lvl2_addr(input logic [31:0] desc, input logic [31:0] mva);
    return (desc & 32'hFFFF_FC00) | ((mva >> 10) & 32'h0000_03FC);
  endfunction

  function automatic logic [1:0] dom_field(input logic [31:0] domacc, input logic [DOM_W-1:0] dom);
    return 2'((domacc >> {dom, 1'b0}) & 32'h3);
  endfunction

  // {read, write} granted by a 2-bit permission field
  function automatic logic [1:0] ap_grant(input logic [1:0] ap, input logic user,
                                          input logic [1:0] rmode);
    logic [1:0] g;
    case (ap)
      2'd0:    g = {(rmode == 2'd2) || ((rmode == 2'd1) && !user), 1'b0};
      2'd1:    g = {!user, !user};
      2'd2:    g = {1'b1, !user};
      default: g = 2'b11;
    endcase
    return g;
  endfunction

  function automatic logic access_ok(input logic [1:0] g, input logic [1:0] kind);
    return (kind == KIND_WRITE) ? g[0] : g[1];
  endfunction

  function automatic logic [1:0] sub_ap(input logic [31:0] desc, input logic [1:0] idx);
    return 2'((desc >> (32'd4 + 32'({idx, 1'b0}))) & 32'h3);
  endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [31:0]       desc,
  input  logic [31:0]       mva,
  input  logic [31:0]       domacc,
  input  logic [1:0]        kind,
  input  logic              user,
  input  logic [1:0]        rmode,
  output logic              is_fault,
  output logic [CODE_W-1:0] code,
  output logic              is_table,
  output logic [DOM_W-1:0]  dom_num,
  output logic [1:0]        dom_val,
  output logic [31:0]       sect_pa,
  output logic [1:0]        grant,
  output logic [31:0]       next_addr
);
  always_comb begin
    dom_num   = desc[8:5];
    dom_val   = dom_field(domacc, desc[8:5]);
    sect_pa   = {desc[31:20], mva[19:0]};
    next_addr = lvl2_addr(desc, mva);
    grant     = (dom_val == 2'd3) ? 2'b11 : ap_grant(desc[11:10], user, rmode);
    is_fault  = 1'b0;
    is_table  = 1'b0;
    code      = '0;
    if (desc[1:0] == 2'd0) begin
      is_fault = 1'b1;
      code     = C_L1_EMPTY;
    end else if (dom_val == 2'd0 || dom_val == 2'd2) begin
      is_fault = 1'b1;
      code     = (desc[1:0] == 2'd2) ? C_DOM_SECT : C_DOM_PAGE;
    end else if (desc[1:0] == 2'd2) begin
      if (!access_ok(grant, kind)) begin
        is_fault = 1'b1;
        code     = C_PERM_SECT;
      end
    end else begin
      is_table = 1'b1;
    end
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [31:0]       desc,
  input  logic [15:0]       mva_lo,
  input  logic [1:0]        l1_type,
  input  logic [1:0]        dom_val,
  input  logic [1:0]        kind,
  input  logic              user,
  input  logic [1:0]        rmode,
  output logic              is_fault,
  output logic [CODE_W-1:0] code,
  output logic [31:0]       page_pa,
  output logic [1:0]        grant
);
  logic [1:0] ap;
  logic       empty;

  always_comb begin
    empty   = 1'b0;
    ap      = 2'd0;
    page_pa = '0;
    case (desc[1:0])
      2'd0: empty = 1'b1;
      2'd1: begin
        page_pa = {desc[31:16], mva_lo[15:0]};
        ap      = sub_ap(desc, mva_lo[15:14]);
      end
      2'd2: begin
        page_pa = {desc[31:12], mva_lo[11:0]};
        ap      = sub_ap(desc, mva_lo[11:10]);
      end
      default: begin
        empty   = (l1_type == 2'd1);
        page_pa = {desc[31:10], mva_lo[9:0]};
        ap      = sub_ap(desc, 2'd0);
      end
    endcase
    grant    = (dom_val == 2'd3) ? 2'b11 : ap_grant(ap, user, rmode);
    is_fault = 1'b0;
    code     = '0;
    if (empty) begin
      is_fault = 1'b1;
      code     = C_L2_EMPTY;
    end else if (!access_ok(grant, kind)) begin
      is_fault = 1'b1;
      code     = C_PERM_PAGE;
    end
  end
endmodule

// File: rtl/ptw_fault_log.sv
module ptw_fault_log
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic              is_fetch,
  input  logic [STAT_W-1:0] stat,
  input  logic [AW-1:0]     addr,
  output logic [STAT_W-1:0] i_stat,
  output logic [AW-1:0]     i_addr,
  output logic [STAT_W-1:0] d_stat,
  output logic [AW-1:0]     d_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_stat <= '0;
      i_addr <= '0;
      d_stat <= '0;
      d_addr <= '0;
    end else if (log_en) begin
      if (is_fetch) begin
        i_stat <= stat;
        i_addr <= addr;
      end else begin
        d_stat <= stat;
        d_addr <= addr;
      end
    end
  end

  a_r10_fetch_side: assert property (@(posedge clk) disable iff (!rst_n)
    (log_en && is_fetch) |=> (i_stat == $past(stat)) && (i_addr == $past(addr)) && $stable(d_stat));
  a_r10_data_side: assert property (@(posedge clk) disable iff (!rst_n)
    (log_en && !is_fetch) |=> (d_stat == $past(stat)) && (d_addr == $past(addr)) && $stable(i_stat));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [31:0]       cfg_base,
  input  logic [31:0]       cfg_domacc,
  input  logic [31:0]       cfg_ctrl,
  input  logic [31:0]       cfg_pid,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [AW-1:0]     res_pa,
  output logic              res_rd,
  output logic              res_wr,
  output logic [STAT_W-1:0] res_status,
  output logic [STAT_W-1:0] ifault_status,
  output logic [AW-1:0]     ifault_addr,
  output logic [STAT_W-1:0] dfault_status,
  output logic [AW-1:0]     dfault_addr
);
  walk_st_e          st;
  logic [AW-1:0]     va_q, mva_q, l2addr_q;
  logic [1:0]        kind_q, l1type_q, domval_q;
  logic              user_q;
  logic [DOM_W-1:0]  dom_q;

  // named internal events
  logic [AW-1:0]     mva_in;
  logic              xlate_en, accept, l1_arrive, l2_arrive, walk_fault_evt;
  logic [1:0]        rmode;
  logic [STAT_W-1:0] evt_status;

  logic              l1_fault, l1_table, l2_fault;
  logic [CODE_W-1:0] l1_code, l2_code;
  logic [DOM_W-1:0]  l1_dom;
  logic [1:0]        l1_domval, l1_grant, l2_grant;
  logic [31:0]       l1_pa, l1_next, l2_pa;

  assign mva_in    = relocate(req_va, cfg_pid, RELOC_LIMIT);
  assign xlate_en  = cfg_ctrl[0];
  assign rmode     = 2'((cfg_ctrl >> 8) & 32'h3);
  assign accept    = (st == W_IDLE) && req_valid;
  assign l1_arrive = (st == W_LVL1) && mem_valid;
  assign l2_arrive = (st == W_LVL2) && mem_valid;
  assign walk_fault_evt = (l1_arrive && l1_fault) || (l2_arrive && l2_fault);
  assign evt_status = l1_arrive ? {l1_dom, l1_code} : {dom_q, l2_code};

  assign mem_req  = (st == W_LVL1) || (st == W_LVL2);
  assign mem_addr = (st == W_LVL1) ? lvl1_addr(cfg_base, mva_q) : l2addr_q;
  assign busy     = (st != W_IDLE);

  ptw_l1_decode u_l1 (
    .desc(mem_data), .mva(mva_q), .domacc(cfg_domacc), .kind(kind_q), .user(user_q),
    .rmode(rmode), .is_fault(l1_fault), .code(l1_code), .is_table(l1_table),
    .dom_num(l1_dom), .dom_val(l1_domval), .sect_pa(l1_pa), .grant(l1_grant),
    .next_addr(l1_next)
  );

  ptw_l2_decode u_l2 (
    .desc(mem_data), .mva_lo(mva_q[15:0]), .l1_type(l1type_q), .dom_val(domval_q),
    .kind(kind_q), .user(user_q), .rmode(rmode), .is_fault(l2_fault), .code(l2_code),
    .page_pa(l2_pa), .grant(l2_grant)
  );

  ptw_fault_log #(.AW(AW)) u_log (
    .clk(clk), .rst_n(rst_n), .log_en(walk_fault_evt), .is_fetch(kind_q == KIND_FETCH),
    .stat(evt_status), .addr(va_q), .i_stat(ifault_status), .i_addr(ifault_addr),
    .d_stat(dfault_status), .d_addr(dfault_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE;
      va_q <= '0; mva_q <= '0; l2addr_q <= '0;
      kind_q <= '0; user_q <= 1'b0; l1type_q <= '0; domval_q <= '0; dom_q <= '0;
      done <= 1'b0; fault <= 1'b0;
      res_pa <= '0; res_rd <= 1'b0; res_wr <= 1'b0; res_status <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        W_IDLE: if (accept) begin
          va_q   <= req_va;
          mva_q  <= mva_in;
          kind_q <= req_kind;
          user_q <= req_user;
          if (!xlate_en) begin
            res_pa <= mva_in; res_rd <= 1'b1; res_wr <= 1'b1; res_status <= '0;
            done   <= 1'b1;
            st     <= W_DONE;
          end else begin
            st <= W_LVL1;
          end
        end
        W_LVL1: if (mem_valid) begin
          l1type_q <= mem_data[1:0];
          dom_q    <= l1_dom;
          domval_q <= l1_domval;
          l2addr_q <= l1_next;
          if (l1_fault) begin
            res_status <= evt_status; res_rd <= 1'b0; res_wr <= 1'b0;
            fault <= 1'b1;
            st    <= W_DONE;
          end else if (l1_table) begin
            st <= W_LVL2;
          end else begin
            res_pa <= l1_pa; res_rd <= l1_grant[1]; res_wr <= l1_grant[0]; res_status <= '0;
            done <= 1'b1;
            st   <= W_DONE;
          end
        end
        W_LVL2: if (mem_valid) begin
          if (l2_fault) begin
            res_status <= evt_status; res_rd <= 1'b0; res_wr <= 1'b0;
            fault <= 1'b1;
          end else begin
            res_pa <= l2_pa; res_rd <= l2_grant[1]; res_wr <= l2_grant[0]; res_status <= '0;
            done <= 1'b1;
          end
          st <= W_DONE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, fault}));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault) && !busy);
  a_r11_busy_through: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);
  a_r11_fetch_in_walk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlate_en) |=> done && !mem_req && (res_pa == $past(mva_in)));
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r4_domain_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_arrive && mem_data[1:0] != 2'd0 && !l1_domval[0]) |=>
      fault && (res_status[3:0] == C_DOM_SECT || res_status[3:0] == C_DOM_PAGE));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [31:0] cfg_base = '0, cfg_domacc = '0, cfg_ctrl = '0, cfg_pid = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_data = '0;
  logic        busy, done, fault, res_rd, res_wr;
  logic [31:0] res_pa, ifault_addr, dfault_addr;
  logic [7:0]  res_status, ifault_status, dfault_status;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] mem [logic [31:0]];
  int          tot_acc = 0;
  logic [31:0] acc_log [64];
  int          lat_cnt = 0;

  logic [7:0]  e_istat = '0, e_dstat = '0;
  logic [31:0] e_iaddr = '0, e_daddr = '0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
    .req_user(req_user), .cfg_base(cfg_base), .cfg_domacc(cfg_domacc), .cfg_ctrl(cfg_ctrl),
    .cfg_pid(cfg_pid), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .busy(busy), .done(done), .fault(fault), .res_pa(res_pa),
    .res_rd(res_rd), .res_wr(res_wr), .res_status(res_status), .ifault_status(ifault_status),
    .ifault_addr(ifault_addr), .dfault_status(dfault_status), .dfault_addr(dfault_addr)
  );

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: answers a request after 0..2 extra cycles
  always @(negedge clk) begin
    if (mem_req && !mem_valid) begin
      if (lat_cnt >= (tot_acc % 3)) begin
        mem_valid <= 1'b1;
        mem_data  <= rd_mem(mem_addr);
        acc_log[tot_acc % 64] = mem_addr;
        tot_acc   = tot_acc + 1;
        lat_cnt   = 0;
      end else lat_cnt = lat_cnt + 1;
    end else mem_valid <= 1'b0;
    if (mem_req && !busy) begin
      vectors++; miscompares++;
      $display("FAIL R11: mem_req=1 with busy=0 (expected busy 1)");
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference of the walk
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind, input logic user,
                          output bit flt, output logic [7:0] st, output logic [31:0] pa,
                          output bit r, output bit w, output int nacc,
                          output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] m, d1, d2;
    int t1, t2, dn, dv, ap, code, rm;
    bit empty;
    m = (va < 32'h0200_0000) ? va + cfg_pid : va;
    flt = 0; st = 0; pa = 0; r = 0; w = 0; nacc = 0; a1 = 0; a2 = 0;
    rm = int'((cfg_ctrl >> 8) & 3);
    if (cfg_ctrl[0] == 1'b0) begin pa = m; r = 1; w = 1; return; end
    a1 = {cfg_base[31:14], m[31:20], 2'b00};
    d1 = rd_mem(a1); nacc = 1;
    t1 = int'(d1 & 3); dn = int'((d1 >> 5) & 15); dv = int'((cfg_domacc >> (2 * dn)) & 3);
    empty = 0; ap = 0; code = 0;
    if (t1 == 0) begin empty = 1; code = 5; end
    else if (dv == 0 || dv == 2) begin empty = 1; code = (t1 == 2) ? 9 : 11; end
    else if (t1 == 2) begin
      pa = {d1[31:20], m[19:0]}; ap = int'((d1 >> 10) & 3); code = 13;
    end else begin
      a2 = {d1[31:10], m[19:12], 2'b00};
      d2 = rd_mem(a2); nacc = 2; t2 = int'(d2 & 3); code = 15;
      if (t2 == 0 || (t2 == 3 && t1 == 1)) begin empty = 1; code = 7; end
      else if (t2 == 1) begin pa = {d2[31:16], m[15:0]}; ap = int'((d2 >> (4 + 2 * m[15:14])) & 3); end
      else if (t2 == 2) begin pa = {d2[31:12], m[11:0]}; ap = int'((d2 >> (4 + 2 * m[11:10])) & 3); end
      else begin pa = {d2[31:10], m[9:0]}; ap = int'((d2 >> 4) & 3); end
    end
    if (!empty) begin
      if (dv == 3) begin r = 1; w = 1; end
      else if (ap == 3) begin r = 1; w = 1; end
      else if (ap == 2) begin r = 1; w = !user; end
      else if (ap == 1) begin r = !user; w = !user; end
      else begin w = 0; r = (rm == 2) || (rm == 1 && !user); end
      if ((kind == 2'd1) ? !w : !r) empty = 1;
    end
    if (empty) begin flt = 1; st = 8'(code + 16 * dn); pa = 0; r = 0; w = 0; end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic user,
                      input string tag, input bit stray = 0);
    bit ef, er, ew;
    logic [7:0] es;
    logic [31:0] ep, a1, a2;
    int n, start, cyc;
    ref_walk(va, kind, user, ef, es, ep, er, ew, n, a1, a2);
    start = tot_acc;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_kind = kind; req_user = user;
    @(negedge clk);
    if (stray) req_va = ~va; else req_valid = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 60) begin
      check({tag, " R11 busy during walk"}, 32'(busy), 32'd1);
      @(negedge clk); cyc++;
    end
    if (cyc >= 60) begin
      vectors++; miscompares++;
      $display("FAIL %s R11: walk timed out (actual no result, expected done or fault)", tag);
    end
    req_valid = 1'b0;
    check({tag, " R11 busy with result"}, 32'(busy), 32'd1);
    check({tag, " R11 fault flag"}, 32'(fault), 32'(ef));
    check({tag, " R11 done flag"}, 32'(done), 32'(!ef));
    if (ef) check({tag, " R10 status"}, 32'(res_status), 32'(es));
    else begin
      check({tag, " pa"}, res_pa, ep);
      check({tag, " R9 rd"}, 32'(res_rd), 32'(er));
      check({tag, " R9 wr"}, 32'(res_wr), 32'(ew));
    end
    check({tag, " R3 R7 access count"}, 32'(tot_acc - start), 32'(n));
    if (n >= 1) check({tag, " R3 level-1 address"}, acc_log[start % 64], a1);
    if (n >= 2) check({tag, " R7 level-2 address"}, acc_log[(start + 1) % 64], a2);
    if (ef) begin
      if (kind == 2'd2) begin e_istat = es; e_iaddr = va; end
      else begin e_dstat = es; e_daddr = va; end
    end
    check({tag, " R10 fetch status reg"}, 32'(ifault_status), 32'(e_istat));
    check({tag, " R10 fetch addr reg"}, ifault_addr, e_iaddr);
    check({tag, " R10 data status reg"}, 32'(dfault_status), 32'(e_dstat));
    check({tag, " R10 data addr reg"}, dfault_addr, e_daddr);
    @(negedge clk);
    check({tag, " R11 idle after result"}, 32'(busy | done | fault), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mem[32'h0000_4C00] = 32'h8AB0_0802;  // section dom0 ap2
    mem[32'h0000_4C04] = 32'h0000_00A0;  // empty, dom5
    mem[32'h0000_4C08] = 32'h0000_0042;  // section dom2 (no access)
    mem[32'h0000_4C0C] = 32'h0000_0061;  // coarse dom3 (reserved)
    mem[32'h0000_4C10] = 32'h1230_0022;  // section dom1 (manager) ap0
    mem[32'h0000_4C14] = 32'h0001_0001;  // coarse dom0
    mem[32'h0000_4C18] = 32'h0002_0003;  // fine dom0
    mem[32'h0000_4018] = 32'h0000_0080;  // empty, dom4
    mem[32'h0000_401C] = 32'h4440_0022;  // section dom1
    mem[32'h0001_0000] = 32'h5555_51B2;  // 4 KB, subpage aps 3,2,1,0
    mem[32'h0001_0004] = 32'h0000_0000;  // empty page
    mem[32'h0001_0008] = 32'h9999_9C13;  // 1 KB under coarse
    mem[32'h0001_0040] = 32'h6666_0C21;  // 64 KB, sub0 ap2, sub3 ap3
    mem[32'h0002_0000] = 32'h7777_7C03;  // 1 KB ap0
    cfg_base   = 32'h0000_4ABC;
    cfg_pid    = 32'h0060_0000;
    cfg_domacc = 32'h0000_058D;
    repeat (3) @(negedge clk);
    check("R11 reset busy", 32'(busy), 32'd0);
    check("R11 reset done/fault", 32'({done, fault}), 32'd0);
    check("R11 reset mem_req", 32'(mem_req), 32'd0);
    check("R10 reset records", 32'({ifault_status, dfault_status}), 32'd0);
    rst_n = 1'b1;

    cfg_ctrl = 32'h0;
    walk(32'h0012_3456, 2'd0, 1'b1, "R2 R1 bypass relocated");
    walk(32'h3000_0010, 2'd1, 1'b1, "R2 bypass high");

    cfg_ctrl = 32'h1;
    walk(32'h3001_2345, 2'd0, 1'b1, "R6 section user read");
    walk(32'h3000_0004, 2'd1, 1'b1, "R6 section user write");
    walk(32'h3000_0004, 2'd1, 1'b0, "R6 section priv write");
    walk(32'h3001_0000, 2'd2, 1'b1, "R6 section fetch");
    walk(32'h3010_0000, 2'd2, 1'b0, "R3 empty fetch");
    walk(32'h3010_0000, 2'd0, 1'b0, "R3 empty read");
    walk(32'h3020_0000, 2'd0, 1'b0, "R4 section no-access");
    walk(32'h3030_0000, 2'd1, 1'b0, "R4 table reserved domain");
    walk(32'h3040_0ABC, 2'd1, 1'b1, "R5 manager");
    walk(32'h0010_0040, 2'd0, 1'b1, "R1 relocated section");
    walk(32'h0000_1000, 2'd2, 1'b1, "R1 relocated fault addr");
    walk(32'h0200_0000, 2'd0, 1'b0, "R1 limit not relocated");
    walk(32'h01FF_FFFC, 2'd0, 1'b0, "R1 just below limit");
    walk(32'h3050_0010, 2'd1, 1'b1, "R8 small sub0");
    walk(32'h3050_0810, 2'd0, 1'b1, "R8 small sub2 user");
    walk(32'h3050_0810, 2'd0, 1'b0, "R8 small sub2 priv");
    walk(32'h3050_0C00, 2'd1, 1'b0, "R8 R9 small sub3 write");
    walk(32'h3050_0400, 2'd1, 1'b1, "R9 small sub1 user write");
    walk(32'h3050_1000, 2'd0, 1'b0, "R7 empty page");
    walk(32'h3050_2000, 2'd0, 1'b0, "R7 tiny under coarse");
    walk(32'h3051_0000, 2'd1, 1'b1, "R8 large sub0 write", 1);
    walk(32'h3051_C123, 2'd1, 1'b1, "R8 large sub3");
    walk(32'h3051_0010, 2'd2, 1'b1, "R8 large sub0 fetch");
    walk(32'h3060_0123, 2'd0, 1'b0, "R9 ap0 mode0 read");
    cfg_ctrl = 32'h201;
    walk(32'h3060_0123, 2'd0, 1'b1, "R9 R8 tiny ap0 mode2");
    walk(32'h3060_0123, 2'd1, 1'b0, "R9 ap0 write");
    cfg_ctrl = 32'h101;
    walk(32'h3060_0123, 2'd0, 1'b1, "R9 ap0 mode1 user");
    walk(32'h3060_0123, 2'd2, 1'b0, "R9 ap0 mode1 priv fetch");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule